// File: doc/BRIEF.md
# Dual-Port Register File with Byte Parity

This block is a synchronous two-port storage array for use as a register file or FIFO backing store. Both ports share one clock. Each port has its own address, write data, write enable and byte enables, so any pairing of two reads, two writes, or one read and one write can happen on the same edge. An even parity bit is kept for every data byte. It is computed from the write data when a byte is stored and checked again when the word is read out.

Each port reports whether the word it returned had consistent parity. A single error output flags a mismatch on either port. A build-time parameter selects the read path: a registered path that presents data one cycle after the address is sampled, or a flow-through path that presents data in the same cycle. A standby input parks the array. It cancels reads in flight and blocks every access while it is high and for one guard cycle after it falls. A synchronous reset clears every word together with its parity. A parity-flip input lets test code store deliberately bad parity.

Top module: `dpram_parity`

## Requirements
- R1: On a rising edge where a port's write enable is high, each byte i whose enable bit i is set (bit i covers data bits 8i+7 down to 8i) is stored at that port's address, and later reads of that address return it.
- R2: A port reads when its write enable is low. With PIPELINED=1 the word appears on its read-data output in the cycle after the address is sampled. With PIPELINED=0 it appears combinationally in the same cycle.
- R3: Bytes whose enable bit is clear keep their previous contents and previous parity.
- R4: When both ports write the same address in one cycle, port B's byte wins wherever both ports enable that byte. Bytes enabled by only one port take that port's data.
- R5: A read on one port of an address that the other port writes in the same cycle returns the contents from before the write.
- R6: The parity bit of byte i is the XOR of its eight data bits (even parity). A reading port's parity-ok output is high when the stored parity matches the data it returns. A port that is writing drives read data zero and parity-ok low.
- R7: While par_flip is high, the parity bits of written bytes are stored inverted. A later read of such a word drives that port's parity-ok low, and par_err is high whenever either reading port sees a mismatch.
- R8: While sleep is high, both read-data outputs are zero, both parity-ok outputs are low and par_err is low. A registered read whose result cycle finds sleep high is cancelled.
- R9: Writes are ignored, and reads return zero, in every cycle where sleep is high and in the first cycle after sleep falls.
- R10: A cycle with rst high clears every word and parity bit. During that cycle and the cycle after it, the read outputs are zero and par_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous clear of the array and read state |
| sleep | input | 1 | Standby request |
| par_flip | input | 1 | Store inverted parity for bytes written this cycle |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_wen | input | 1 | Port A write enable (high = write, low = read) |
| a_be | input | DATA_W/8 | Port A byte enables |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_wen | input | 1 | Port B write enable |
| b_be | input | DATA_W/8 | Port B byte enables |
| a_rdata | output | DATA_W | Port A read data |
| a_par_ok | output | 1 | Port A parity matched on the returned word |
| b_rdata | output | DATA_W | Port B read data |
| b_par_ok | output | 1 | Port B parity matched on the returned word |
| par_err | output | 1 | Parity mismatch seen on either port |

## Verification
The bench runs a registered instance and a flow-through instance side by side against a behavioural model. It sweeps every address with arithmetic data and every byte-enable pattern. It also targets the cycle where both ports hit one address: a design that let port A win, or that blended the two writers' bytes wrongly, returns the wrong word, and a read path that sees the new data during a same-cycle write returns fresh data where the old word is expected. The standby sequences check that a registered read is cancelled by sleep and that a write in the guard cycle after wake is dropped; a design without that guard leaves the corrupted word visible afterwards. Bad parity is stored on one byte and read from each port in turn, which catches an error flag that follows only one port.

// File: rtl/dpram_parity.sv
module dpram_parity #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              par_flip,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_wen,
  input  logic [DATA_W/8-1:0] a_be,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_wen,
  input  logic [DATA_W/8-1:0] b_be,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_par_ok,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_par_ok,
  output logic              par_err
);
  localparam int NB    = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [NB-1:0]     mem_p [DEPTH];
  logic              sleep_q, blocked;

  logic [1:0][ADDR_W-1:0] addr;
  logic [1:0][DATA_W-1:0] wdata, out_d;
  logic [1:0][NB-1:0]     be, wpar;
  logic [1:0]             wen, ok, bad;

  function automatic logic [NB-1:0] byte_par(input logic [DATA_W-1:0] d);
    for (int i = 0; i < NB; i++) byte_par[i] = ^d[8*i +: 8];
  endfunction

  assign addr    = {b_addr, a_addr};
  assign wdata   = {b_wdata, a_wdata};
  assign be      = {b_be, a_be};
  assign wen     = {b_wen, a_wen};
  assign blocked = rst | sleep | sleep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
      for (int w = 0; w < DEPTH; w++) begin
        mem_d[w] <= '0;
        mem_p[w] <= '0;
      end
    end else begin
      sleep_q <= sleep;
      if (!blocked)
        for (int p = 0; p < 2; p++)
          for (int i = 0; i < NB; i++)
            if (wen[p] && be[p][i]) begin
              mem_d[addr[p]][8*i +: 8] <= wdata[p][8*i +: 8];
              mem_p[addr[p]][i]        <= wpar[p][i];
            end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [DATA_W-1:0] rd_d;
    logic [NB-1:0]     rd_p;
    logic              rd_v, live;

    assign wpar[p] = byte_par(wdata[p]) ^ {NB{par_flip}};

    if (PIPELINED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          rd_v <= 1'b0;
          rd_d <= '0;
          rd_p <= '0;
        end else begin
          rd_v <= !wen[p] && !blocked;
          rd_d <= mem_d[addr[p]];
          rd_p <= mem_p[addr[p]];
        end
      end
    end else begin : g_flow
      assign rd_v = !wen[p] && !blocked;
      assign rd_d = mem_d[addr[p]];
      assign rd_p = mem_p[addr[p]];
    end

    assign live     = rd_v && !sleep && !rst;
    assign out_d[p] = live ? rd_d : '0;
    assign ok[p]    = live && (byte_par(rd_d) == rd_p);
    assign bad[p]   = live && (byte_par(rd_d) != rd_p);
  end

  assign a_rdata  = out_d[0];
  assign b_rdata  = out_d[1];
  assign a_par_ok = ok[0];
  assign b_par_ok = ok[1];
  assign par_err  = |bad;
endmodule

module dpram_parity_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter bit PIPELINED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              a_wen,
  input logic              b_wen,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_par_ok,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_par_ok,
  input logic              par_err
);
  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (a_rdata == '0 && b_rdata == '0 && !a_par_ok && !b_par_ok && !par_err));

  p_wake_guard_r9: assert property (@(posedge clk) disable iff (rst)
    $past(sleep) |-> (!a_par_ok && !b_par_ok && !par_err));

  p_err_needs_bad_port_r7: assert property (@(posedge clk) disable iff (rst)
    par_err |-> (!a_par_ok || !b_par_ok));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (a_rdata == '0 && b_rdata == '0 && !par_err));

  if (PIPELINED) begin : g_pipe
    p_write_no_read_a_r6: assert property (@(posedge clk) disable iff (rst)
      $past(a_wen) |-> (a_rdata == '0 && !a_par_ok));
    p_write_no_read_b_r6: assert property (@(posedge clk) disable iff (rst)
      $past(b_wen) |-> (b_rdata == '0 && !b_par_ok));
  end else begin : g_flow
    p_write_no_read_a_r6: assert property (@(posedge clk) disable iff (rst)
      a_wen |-> (a_rdata == '0 && !a_par_ok));
    p_write_no_read_b_r6: assert property (@(posedge clk) disable iff (rst)
      b_wen |-> (b_rdata == '0 && !b_par_ok));
  end
endmodule

bind dpram_parity dpram_parity_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIPELINED(PIPELINED)
) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .a_wen(a_wen), .b_wen(b_wen),
  .a_rdata(a_rdata), .a_par_ok(a_par_ok), .b_rdata(b_rdata),
  .b_par_ok(b_par_ok), .par_err(par_err)
);

// File: tb/tb_dpram_parity.sv
`timescale 1ns/1ps
module tb_dpram_parity;
  localparam int DW = 32, AW = 4, NB = DW / 8, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, sleep = 1'b0, par_flip = 1'b0;
  logic [1:0][AW-1:0] addr_i = '0;
  logic [1:0][DW-1:0] wdata_i = '0;
  logic [1:0]         wen_i = '0;
  logic [1:0][NB-1:0] be_i = '0;

  logic [1:0][DW-1:0] rd_pl, rd_ft;
  logic [1:0]         ok_pl, ok_ft;
  logic               err_pl, err_ft;

  dpram_parity #(.DATA_W(DW), .ADDR_W(AW), .PIPELINED(1'b1)) dut (
    .clk(clk), .rst(rst), .sleep(sleep), .par_flip(par_flip),
    .a_addr(addr_i[0]), .a_wdata(wdata_i[0]), .a_wen(wen_i[0]), .a_be(be_i[0]),
    .b_addr(addr_i[1]), .b_wdata(wdata_i[1]), .b_wen(wen_i[1]), .b_be(be_i[1]),
    .a_rdata(rd_pl[0]), .a_par_ok(ok_pl[0]), .b_rdata(rd_pl[1]), .b_par_ok(ok_pl[1]),
    .par_err(err_pl));

  dpram_parity #(.DATA_W(DW), .ADDR_W(AW), .PIPELINED(1'b0)) dut_ft (
    .clk(clk), .rst(rst), .sleep(sleep), .par_flip(par_flip),
    .a_addr(addr_i[0]), .a_wdata(wdata_i[0]), .a_wen(wen_i[0]), .a_be(be_i[0]),
    .b_addr(addr_i[1]), .b_wdata(wdata_i[1]), .b_wen(wen_i[1]), .b_be(be_i[1]),
    .a_rdata(rd_ft[0]), .a_par_ok(ok_ft[0]), .b_rdata(rd_ft[1]), .b_par_ok(ok_ft[1]),
    .par_err(err_ft));

  int n_cmp = 0, n_bad = 0;
  string tag = "R10";
  logic nx_rst = 1'b1, nx_sleep = 1'b0, nx_flip = 1'b0;

  logic [DW-1:0] md [DEPTH];
  logic [NB-1:0] mp [DEPTH];
  logic          sq_m = 1'b0;
  logic [1:0]    pv = '0, pok = '0;
  logic [1:0][DW-1:0] pdat = '0;

  function automatic logic [NB-1:0] par(input logic [DW-1:0] d);
    for (int i = 0; i < NB; i++) par[i] = ^d[8*i +: 8];
  endfunction

  function automatic logic [DW-1:0] pat(input int i);
    return (i + 1) * 32'h9E37_79B9 ^ 32'h0F1E_2D3C;
  endfunction

  task automatic cmp(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic aw, input int aa, input logic [DW-1:0] ad, input logic [NB-1:0] abe,
                      input logic bw, input int ba, input logic [DW-1:0] bd, input logic [NB-1:0] bbe);
    logic blk, e_err_f, e_err_p, live;
    logic [1:0] fv, fok;
    logic [1:0][DW-1:0] fd;
    @(negedge clk);
    rst = nx_rst; sleep = nx_sleep; par_flip = nx_flip;
    wen_i = {bw, aw}; addr_i = {ba[AW-1:0], aa[AW-1:0]};
    wdata_i = {bd, ad}; be_i = {bbe, abe};
    #1;
    blk = rst | sleep | sq_m;
    e_err_f = 1'b0; e_err_p = 1'b0;
    for (int p = 0; p < 2; p++) begin
      fv[p]  = !wen_i[p] && !blk;
      fd[p]  = fv[p] ? md[addr_i[p]] : '0;
      fok[p] = fv[p] && (par(md[addr_i[p]]) == mp[addr_i[p]]);
      if (fv[p] && !fok[p]) e_err_f = 1'b1;
      cmp($sformatf("flow port%0d rdata", p), rd_ft[p], fd[p]);
      cmp($sformatf("flow port%0d par_ok", p), DW'(ok_ft[p]), DW'(fok[p]));
      live = pv[p] && !sleep && !rst;
      if (live && !pok[p]) e_err_p = 1'b1;
      cmp($sformatf("pipe port%0d rdata", p), rd_pl[p], live ? pdat[p] : '0);
      cmp($sformatf("pipe port%0d par_ok", p), DW'(ok_pl[p]), DW'(live && pok[p]));
    end
    cmp("flow par_err", DW'(err_ft), DW'(e_err_f));
    cmp("pipe par_err", DW'(err_pl), DW'(e_err_p));
    for (int p = 0; p < 2; p++) begin
      pv[p]   = fv[p];
      pdat[p] = md[addr_i[p]];
      pok[p]  = par(md[addr_i[p]]) == mp[addr_i[p]];
    end
    if (rst) begin
      sq_m = 1'b0;
      for (int w = 0; w < DEPTH; w++) begin md[w] = '0; mp[w] = '0; end
    end else begin
      sq_m = sleep;
      if (!blk)
        for (int p = 0; p < 2; p++)
          for (int i = 0; i < NB; i++)
            if (wen_i[p] && be_i[p][i]) begin
              md[addr_i[p]][8*i +: 8] = wdata_i[p][8*i +: 8];
              mp[addr_i[p]][i] = par(wdata_i[p])[i] ^ par_flip;
            end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    for (int w = 0; w < DEPTH; w++) begin md[w] = '0; mp[w] = '0; end
    tag = "R10";
    step(0, 0, '0, '0, 0, 0, '0, '0);
    step(0, 0, '0, '0, 0, 0, '0, '0);
    nx_rst = 1'b0;
    tag = "R1";
    for (int i = 0; i < DEPTH; i++) step(1, i, pat(i), '1, 0, DEPTH-1-i, '0, '0);
    tag = "R2";
    for (int i = 0; i < DEPTH; i++) step(0, i, '0, '0, 0, i ^ 5, '0, '0);
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) step(0, i, '0, '0, 1, i, ~pat(i + 40), NB'(i));
    for (int i = 0; i < DEPTH; i++) step(0, i, '0, '0, 0, DEPTH-1-i, '0, '0);
    tag = "R4";
    step(1, 7, 32'h1111_2222, 4'b1111, 1, 7, 32'hAAAA_BBBB, 4'b0110);
    step(1, 8, 32'h3333_4444, 4'b0011, 1, 8, 32'hCCCC_DDDD, 4'b1100);
    step(0, 7, '0, '0, 0, 8, '0, '0);
    step(0, 8, '0, '0, 0, 7, '0, '0);
    tag = "R5";
    step(0, 9, '0, '0, 1, 9, 32'h5A5A_0001, 4'b1111);
    step(1, 10, 32'h0BAD_F00D, 4'b1111, 0, 10, '0, '0);
    step(0, 9, '0, '0, 0, 10, '0, '0);
    tag = "R6";
    step(1, 2, 32'h8001_7F00, 4'b1111, 0, 2, '0, '0);
    step(0, 2, '0, '0, 1, 3, 32'h0000_0001, 4'b0001);
    step(0, 3, '0, '0, 0, 2, '0, '0);
    tag = "R7";
    nx_flip = 1'b1;
    step(1, 4, 32'h0102_0304, 4'b0010, 0, 0, '0, '0);
    nx_flip = 1'b0;
    step(0, 4, '0, '0, 0, 11, '0, '0);
    step(0, 11, '0, '0, 0, 4, '0, '0);
    step(0, 4, '0, '0, 0, 4, '0, '0);
    step(1, 4, 32'h0102_0304, 4'b0010, 0, 4, '0, '0);
    step(0, 4, '0, '0, 0, 4, '0, '0);
    tag = "R8";
    step(0, 1, '0, '0, 0, 2, '0, '0);
    nx_sleep = 1'b1;
    for (int k = 0; k < 3; k++) step(1, 1, 32'hDEAD_0000 + k, 4'b1111, 0, 2, '0, '0);
    tag = "R9";
    nx_sleep = 1'b0;
    step(1, 1, 32'hFACE_FACE, 4'b1111, 1, 2, 32'hCAFE_CAFE, 4'b1111);
    step(0, 1, '0, '0, 0, 2, '0, '0);
    step(0, 2, '0, '0, 0, 1, '0, '0);
    tag = "R10";
    nx_rst = 1'b1;
    step(1, 5, 32'h7777_7777, 4'b1111, 0, 6, '0, '0);
    nx_rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) step(0, i, '0, '0, 0, DEPTH-1-i, '0, '0);
    step(0, 0, '0, '0, 0, 0, '0, '0);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end
endmodule